// File: doc/BRIEF.md
# Debug trigger sequencer

This block is a four-channel debug trigger sequencer. Comparators elsewhere in the chip detect tag hits and deliver them as one-cycle pulses, one bit per channel. After software arms the sequencer, it walks through up to three intermediate states. Each state holds a small bank of rules. A rule names a channel and the state that a hit on that channel leads to. When the walk reaches the final state, the block issues a one-cycle breakpoint request and disarms itself over two clock cycles.

Software controls the block through a control write and a rule write. The control write carries an arm bit, a software trigger bit and a channel-map field. The rule write targets one rule slot of one state. Three outputs report progress: the current state, a register with one sticky flag bit per channel, and a saturating event counter. Each transition caused by a hit sets the flag bit of that channel and adds one to the counter.

The design handles two awkward cases explicitly. First, an arm write that lands in the last disarm cycle is arbitrated so that the block is either fully re-armed or fully disarmed; it is never disarmed while reporting state one. Second, when several channels hit in the same cycle, priority is resolved only among channels that have a rule in the current state, so a hit on a lower channel without a rule cannot hide a higher channel's hit.

Top module: `dts_sequencer`

## Requirements
- R1: After reset, armed is 0, state reads 3 (final), the flag and counter outputs are 0, breakpoint is 0 and the map output is 0.
- R2: A control write with the arm bit, while disarmed and not disarming, arms the block on the next edge: state reads 0 (state one), and the flags and counter read 0.
- R3: A rule is 4 bits: bits [1:0] select the channel and bits [3:2] select the target, where 0 means unused, 1 means state two (reads 1), 2 means state three (reads 2) and 3 means final (reads 3). Rule address = {state index (0..2 for states one..three), slot bit}. While armed, a hit on a channel that has a used rule in the current state moves to that rule's target on the next edge.
- R4: Every hit-driven transition sets the flag bit of the winning channel and adds one to the event counter. The counter saturates at its all-ones value.
- R5: Among simultaneous hits, the lowest-numbered channel with a used rule in the current state wins. If both slots name the same channel, slot 0's target is taken. Hits on channels without a rule change nothing.
- R6: A lower channel's hit without a rule does not block a higher channel's hit whose rule leads to final; the breakpoint is still issued.
- R7: Entering final raises the breakpoint output for exactly one cycle, in the same cycle that state first reads 3. Armed stays 1 for that cycle and the next one, then drops.
- R8: A trace-done pulse while armed runs the same two-cycle disarm without a breakpoint. Afterwards state reads 3 and the flags and counter are kept.
- R9: A control write with the trigger bit while armed and not disarming enters final with a breakpoint and leaves the flags and counter unchanged.
- R10: A control write while armed always updates the map output. Outside the last disarm cycle it does not reinitialise the state, the flags or the counter.
- R11: An arm write in the last disarm cycle re-arms the block fully (state 0, flags 0, counter 0). An arm write in the first disarm cycle is ignored. Whenever armed reads 0, state reads 3.
- R12: While disarmed, hits change neither the flags nor the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_arm | input | 1 | Arm bit of the control write |
| ctl_trig | input | 1 | Software trigger bit of the control write |
| ctl_map | input | MAP_W | Channel-map field of the control write |
| cfg_we | input | 1 | Rule write strobe |
| cfg_addr | input | 3 | Rule address {state index, slot} |
| cfg_data | input | 4 | Rule code {target, channel} |
| hit | input | 4 | Per-channel tag-hit pulses |
| trace_done | input | 1 | Trace completion pulse, starts a disarm |
| armed_o | output | 1 | Sequencer armed |
| state_o | output | 2 | Current state (0..2 = states one..three, 3 = final) |
| match_o | output | 4 | Sticky per-channel match flags |
| evt_cnt_o | output | CNT_W | Saturating event counter |
| map_o | output | MAP_W | Stored channel-map field |
| brk_req_o | output | 1 | One-cycle breakpoint request |

## Verification
Every result sits one register away from its stimulus. A hit, trigger, arm or rule write presented before an edge shows up on state, flags, counter, breakpoint and map just after that edge. The disarm that follows a breakpoint or trace-done finishes two edges later, and an arm write aimed at the last disarm cycle is therefore presented after the second of those edges. The bench changes inputs a short delay after a rising edge and samples all outputs a short delay after the next rising edge, so each check reads the value due for exactly that edge.

// File: rtl/dts_pkg.sv
package dts_pkg;
  localparam int unsigned NUM_CH   = 4;
  localparam int unsigned CH_W     = $clog2(NUM_CH);
  localparam int unsigned NUM_SEQ  = 3;
  localparam int unsigned NUM_SLOT = 2;
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOT);
  localparam int unsigned ST_W     = 2;
  localparam int unsigned ADDR_W   = ST_W + SLOT_W;
  localparam int unsigned CODE_W   = ST_W + CH_W;

  typedef enum logic [ST_W-1:0] {
    ST_ONE   = 2'd0,
    ST_TWO   = 2'd1,
    ST_THREE = 2'd2,
    ST_FINAL = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic [ST_W-1:0] nxt;
    logic [CH_W-1:0] ch;
  } rule_t;

  typedef enum logic [1:0] {
    DP_NONE  = 2'd0,
    DP_FIRST = 2'd1,
    DP_LAST  = 2'd2
  } dis_phase_e;
endpackage

// File: rtl/dts_rule_bank.sv
module dts_rule_bank
  import dts_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [CODE_W-1:0]        cfg_data,
  input  seq_state_e               cur_state,
  output rule_t [NUM_SLOT-1:0]     act_rules
);
  localparam int unsigned N_RULE = NUM_SEQ * NUM_SLOT;

  rule_t rule_q [N_RULE];

  for (genvar g = 0; g < N_RULE; g++) begin : g_rule
    logic wr_en;
    assign wr_en = cfg_we && (cfg_addr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rule_q[g] <= '0;
      else if (wr_en) rule_q[g] <= rule_t'(cfg_data);
    end
  end

  always_comb begin
    for (int s = 0; s < NUM_SLOT; s++) begin
      act_rules[s] = '0;
      if (cur_state != ST_FINAL)
        act_rules[s] = rule_q[{cur_state, SLOT_W'(s)}];
    end
  end
endmodule

// File: rtl/dts_hit_pick.sv
module dts_hit_pick
  import dts_pkg::*;
(
  input  rule_t [NUM_SLOT-1:0] act_rules,
  input  logic [NUM_CH-1:0]    hit,
  output logic                 take,
  output logic [CH_W-1:0]      take_ch,
  output logic [ST_W-1:0]      take_nxt
);
  logic [NUM_CH-1:0] relevant;
  logic [NUM_CH-1:0] live;

  always_comb begin
    relevant = '0;
    for (int s = 0; s < NUM_SLOT; s++)
      if (act_rules[s].nxt != '0) relevant[act_rules[s].ch] = 1'b1;
  end

  assign live = relevant & hit;

  always_comb begin
    take    = 1'b0;
    take_ch = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (live[c]) begin
        take    = 1'b1;
        take_ch = CH_W'(c);
      end
    end
  end

  always_comb begin
    take_nxt = '0;
    for (int s = NUM_SLOT - 1; s >= 0; s--)
      if (act_rules[s].nxt != '0 && act_rules[s].ch == take_ch)
        take_nxt = act_rules[s].nxt;
  end
endmodule

// File: rtl/dts_seq_ctrl.sv
module dts_seq_ctrl
  import dts_pkg::*;
#(
  parameter int unsigned CNT_W = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_req,
  input  logic              trig_wr,
  input  logic              trace_done,
  input  logic              take,
  input  logic [CH_W-1:0]   take_ch,
  input  logic [ST_W-1:0]   take_nxt,
  output logic              armed,
  output seq_state_e        state,
  output logic [NUM_CH-1:0] flags,
  output logic [CNT_W-1:0]  count,
  output logic              brk
);
  logic              armed_q, armed_d;
  seq_state_e        st_q, st_d;
  dis_phase_e        dis_q, dis_d;
  logic [NUM_CH-1:0] flg_q, flg_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              brk_d, brk_q;
  logic              running;
  logic              go_final;

  assign running  = armed_q && (dis_q == DP_NONE);
  assign go_final = running && ((trig_wr) ||
                    (take && seq_state_e'(take_nxt) == ST_FINAL));

  always_comb begin
    armed_d = armed_q;
    st_d    = st_q;
    dis_d   = dis_q;
    flg_d   = flg_q;
    cnt_d   = cnt_q;
    brk_d   = 1'b0;
    if (!armed_q) begin
      if (arm_req) begin
        armed_d = 1'b1;
        st_d    = ST_ONE;
        flg_d   = '0;
        cnt_d   = '0;
      end
    end else if (dis_q == DP_FIRST) begin
      dis_d = DP_LAST;
    end else if (dis_q == DP_LAST) begin
      dis_d = DP_NONE;
      if (arm_req) begin
        st_d  = ST_ONE;
        flg_d = '0;
        cnt_d = '0;
      end else begin
        armed_d = 1'b0;
        st_d    = ST_FINAL;
      end
    end else begin
      if (take) begin
        flg_d[take_ch] = 1'b1;
        cnt_d = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;
        st_d  = seq_state_e'(take_nxt);
      end
      if (go_final) begin
        st_d  = ST_FINAL;
        brk_d = 1'b1;
        dis_d = DP_FIRST;
      end else if (trace_done) begin
        dis_d = DP_FIRST;
      end
    end
  end

  logic armed_en, st_en, dis_en, flg_en, cnt_en;
  assign armed_en = armed_d != armed_q;
  assign st_en    = st_d != st_q;
  assign dis_en   = dis_d != dis_q;
  assign flg_en   = flg_d != flg_q;
  assign cnt_en   = cnt_d != cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (armed_en) armed_q <= armed_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= ST_FINAL;
    else if (st_en) st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dis_q <= DP_NONE;
    else if (dis_en) dis_q <= dis_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flg_q <= '0;
    else if (flg_en) flg_q <= flg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk_q <= 1'b0;
    else        brk_q <= brk_d;
  end

  assign armed = armed_q;
  assign state = st_q;
  assign flags = flg_q;
  assign count = cnt_q;
  assign brk   = brk_q;
endmodule

// File: rtl/dts_sequencer.sv
module dts_sequencer
  import dts_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned MAP_W = 2
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctl_we,
  input  logic                  ctl_arm,
  input  logic                  ctl_trig,
  input  logic [MAP_W-1:0]      ctl_map,
  input  logic                  cfg_we,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [CODE_W-1:0]     cfg_data,
  input  logic [NUM_CH-1:0]     hit,
  input  logic                  trace_done,
  output logic                  armed_o,
  output logic [ST_W-1:0]       state_o,
  output logic [NUM_CH-1:0]     match_o,
  output logic [CNT_W-1:0]      evt_cnt_o,
  output logic [MAP_W-1:0]      map_o,
  output logic                  brk_req_o
);
  seq_state_e            cur_state;
  rule_t [NUM_SLOT-1:0]  act_rules;
  logic                  take;
  logic [CH_W-1:0]       take_ch;
  logic [ST_W-1:0]       take_nxt;
  logic [MAP_W-1:0]      map_q;

  dts_rule_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_data  (cfg_data),
    .cur_state (cur_state),
    .act_rules (act_rules)
  );

  dts_hit_pick u_pick (
    .act_rules (act_rules),
    .hit       (hit),
    .take      (take),
    .take_ch   (take_ch),
    .take_nxt  (take_nxt)
  );

  dts_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_req    (ctl_we && ctl_arm),
    .trig_wr    (ctl_we && ctl_trig),
    .trace_done (trace_done),
    .take       (take),
    .take_ch    (take_ch),
    .take_nxt   (take_nxt),
    .armed      (armed_o),
    .state      (cur_state),
    .flags      (match_o),
    .count      (evt_cnt_o),
    .brk        (brk_req_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      map_q <= '0;
    else if (ctl_we) map_q <= ctl_map;
  end

  assign state_o = cur_state;
  assign map_o   = map_q;
endmodule

// File: rtl/dts_sequencer_chk.sv
module dts_sequencer_chk #(
  parameter int unsigned CNT_W = 8
)(
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_we,
  input logic             ctl_arm,
  input logic             armed_o,
  input logic [1:0]       state_o,
  input logic [3:0]       match_o,
  input logic [CNT_W-1:0] evt_cnt_o,
  input logic             brk_req_o
);
  assert_disarmed_final_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_o |-> state_o == 2'd3);

  assert_brk_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req_o |=> !brk_req_o);

  assert_brk_in_final_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req_o |-> (armed_o && state_o == 2'd3));

  assert_brk_then_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req_o |=> armed_o);

  assert_arm_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_o) |-> (state_o == 2'd0 && match_o == 4'd0 && evt_cnt_o == '0));

  assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(evt_cnt_o) |-> (evt_cnt_o == $past(evt_cnt_o) + CNT_W'(1) || evt_cnt_o == '0));

  assert_flags_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctl_we && ctl_arm) |-> (($past(match_o) & ~match_o) == 4'd0));

  assert_idle_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!armed_o && !(ctl_we && ctl_arm)) |-> ($stable(match_o) && $stable(evt_cnt_o)));
endmodule

bind dts_sequencer dts_sequencer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_we    (ctl_we),
  .ctl_arm   (ctl_arm),
  .armed_o   (armed_o),
  .state_o   (state_o),
  .match_o   (match_o),
  .evt_cnt_o (evt_cnt_o),
  .brk_req_o (brk_req_o)
);

// File: tb/dts_sequencer_tb.sv
`timescale 1ns/1ps
module dts_sequencer_tb;
  logic       clk, rst_n;
  logic       ctl_we, ctl_arm, ctl_trig;
  logic [1:0] ctl_map;
  logic       cfg_we;
  logic [2:0] cfg_addr;
  logic [3:0] cfg_data;
  logic [3:0] hit;
  logic       trace_done;
  logic       armed_o;
  logic [1:0] state_o;
  logic [3:0] match_o;
  logic [7:0] evt_cnt_o;
  logic [1:0] map_o;
  logic       brk_req_o;

  int n_checks = 0;
  int n_err    = 0;

  dts_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_arm(ctl_arm),
    .ctl_trig(ctl_trig), .ctl_map(ctl_map), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .hit(hit),
    .trace_done(trace_done), .armed_o(armed_o), .state_o(state_o),
    .match_o(match_o), .evt_cnt_o(evt_cnt_o), .map_o(map_o),
    .brk_req_o(brk_req_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] snap();
    return {17'd0, state_o, match_o, evt_cnt_o, brk_req_o};
  endfunction

  function automatic logic [31:0] pack(input int st, input int fl, input int cn, input int bk);
    return {17'd0, st[1:0], fl[3:0], cn[7:0], bk[0]};
  endfunction

  task automatic cfg_write(input logic [2:0] a, input logic [3:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic ctl_write(input logic arm, input logic trig, input logic [1:0] m);
    ctl_we = 1'b1; ctl_arm = arm; ctl_trig = trig; ctl_map = m;
    tick();
    ctl_we = 1'b0; ctl_arm = 1'b0; ctl_trig = 1'b0;
  endtask

  task automatic pulse_hit(input logic [3:0] h);
    hit = h;
    tick();
    hit = 4'd0;
  endtask

  task automatic quiesce();
    ctl_write(1'b0, 1'b1, 2'd0);
    repeat (4) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctl_we = 0; ctl_arm = 0; ctl_trig = 0; ctl_map = 0;
    cfg_we = 0; cfg_addr = 0; cfg_data = 0; hit = 0; trace_done = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    tick();

    // R1 reset state
    check("R1", "armed", {31'd0, armed_o}, 32'd0);
    check("R1", "state/flags/cnt/brk", snap(), pack(3, 0, 0, 0));
    check("R1", "map", {30'd0, map_o}, 32'd0);

    // R12 hits while disarmed
    cfg_write(3'd0, 4'b0100);
    pulse_hit(4'hF);
    check("R12", "disarmed hit", snap(), pack(3, 0, 0, 0));

    // R2 arm
    ctl_write(1'b1, 1'b0, 2'd0);
    check("R2", "armed", {31'd0, armed_o}, 32'd1);
    check("R2", "arm init", snap(), pack(0, 0, 0, 0));
    quiesce();

    // R3 R4 R7: sweep all slot-0 codes against all hit patterns
    for (int code = 0; code < 16; code++) begin
      for (int h = 0; h < 16; h++) begin
        int nx, ch, tk;
        cfg_write(3'd0, code[3:0]);
        cfg_write(3'd1, 4'd0);
        ctl_write(1'b1, 1'b0, 2'd0);
        pulse_hit(h[3:0]);
        nx = code >> 2;
        ch = code & 3;
        tk = (nx != 0 && h[ch]) ? 1 : 0;
        check("R3", $sformatf("code %0d hit %0h", code, h), snap(),
              pack(tk ? nx : 0, tk ? (1 << ch) : 0, tk, (tk && nx == 3) ? 1 : 0));
        quiesce();
      end
    end

    // R5 R6: two rules, slot 0 to state two, slot 1 to final
    for (int ca = 0; ca < 4; ca++) begin
      for (int cb = 0; cb < 4; cb++) begin
        for (int h = 0; h < 16; h++) begin
          int rel, live, win, nx;
          cfg_write(3'd0, {2'd1, ca[1:0]});
          cfg_write(3'd1, {2'd3, cb[1:0]});
          ctl_write(1'b1, 1'b0, 2'd0);
          pulse_hit(h[3:0]);
          rel  = (1 << ca) | (1 << cb);
          live = rel & h;
          win  = -1;
          for (int c = 3; c >= 0; c--) if (live[c]) win = c;
          if (win < 0) begin
            check("R5", $sformatf("none a%0d b%0d h%0h", ca, cb, h), snap(), pack(0, 0, 0, 0));
          end else begin
            nx = (win == ca) ? 1 : 3;
            check("R5", $sformatf("a%0d b%0d h%0h", ca, cb, h), snap(),
                  pack(nx, 1 << win, 1, (nx == 3) ? 1 : 0));
          end
          quiesce();
        end
      end
    end

    // R6 directed: channel 0 hit without a rule, channel 3 leads to final
    cfg_write(3'd0, {2'd3, 2'd3});
    cfg_write(3'd1, 4'd0);
    ctl_write(1'b1, 1'b0, 2'd0);
    pulse_hit(4'b1001);
    check("R6", "higher channel breakpoint", snap(), pack(3, 4'b1000, 1, 1));
    tick();
    check("R7", "brk single", {31'd0, brk_req_o}, 32'd0);
    check("R7", "armed second disarm cycle", {31'd0, armed_o}, 32'd1);
    tick();
    check("R7", "disarmed", {31'd0, armed_o}, 32'd0);
    check("R7", "final kept", snap(), pack(3, 4'b1000, 1, 0));

    // R8 trace completion
    cfg_write(3'd0, {2'd1, 2'd0});
    ctl_write(1'b1, 1'b0, 2'd0);
    pulse_hit(4'b0001);
    trace_done = 1'b1;
    tick();
    trace_done = 1'b0;
    check("R8", "first cycle", {snap()[30:0], armed_o}, {pack(1, 1, 1, 0)[30:0], 1'b1});
    tick();
    check("R8", "second cycle armed", {31'd0, armed_o}, 32'd1);
    tick();
    check("R8", "done", {snap()[30:0], armed_o}, {pack(3, 1, 1, 0)[30:0], 1'b0});

    // R9 software trigger
    ctl_write(1'b1, 1'b0, 2'd0);
    pulse_hit(4'b0001);
    ctl_write(1'b0, 1'b1, 2'd0);
    check("R9", "trigger", snap(), pack(3, 1, 1, 1));
    repeat (2) tick();
    check("R9", "disarmed", {31'd0, armed_o}, 32'd0);

    // R10 write while armed
    ctl_write(1'b1, 1'b0, 2'd0);
    pulse_hit(4'b0001);
    ctl_write(1'b1, 1'b0, 2'd2);
    check("R10", "no reinit", snap(), pack(1, 1, 1, 0));
    check("R10", "map", {30'd0, map_o}, 32'd2);
    quiesce();

    // R11 arm in last disarm cycle
    cfg_write(3'd0, {2'd3, 2'd2});
    ctl_write(1'b1, 1'b0, 2'd0);
    pulse_hit(4'b0100);
    check("R11", "entered final", snap(), pack(3, 4'b0100, 1, 1));
    tick();
    ctl_write(1'b1, 1'b0, 2'd0);
    check("R11", "rearm armed", {31'd0, armed_o}, 32'd1);
    check("R11", "rearm init", snap(), pack(0, 0, 0, 0));
    quiesce();

    // R11 arm in first disarm cycle is ignored
    ctl_write(1'b1, 1'b0, 2'd0);
    pulse_hit(4'b0100);
    ctl_write(1'b1, 1'b0, 2'd0);
    check("R11", "first-cycle arm ignored", {snap()[30:0], armed_o}, {pack(3, 4, 1, 0)[30:0], 1'b1});
    tick();
    check("R11", "disarmed after", {snap()[30:0], armed_o}, {pack(3, 4, 1, 0)[30:0], 1'b0});

    // R4 saturation: state one -> two on ch0, state two self-loop on ch1
    cfg_write(3'd0, {2'd1, 2'd0});
    cfg_write(3'd2, {2'd1, 2'd1});
    cfg_write(3'd3, 4'd0);
    ctl_write(1'b1, 1'b0, 2'd0);
    pulse_hit(4'b0001);
    hit = 4'b0010;
    repeat (300) tick();
    hit = 4'd0;
    check("R4", "saturated", snap(), pack(1, 4'b0011, 255, 0));
    quiesce();

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule